// File: doc/BRIEF.md
# 128-bit Carry Select Adder with Increment Candidates

This block adds two 128-bit unsigned operands and a carry-in and returns a 128-bit sum and a carry-out. It contains no storage. Arithmetic blocks that need a wide add within one cycle, with a shorter carry path than a single ripple chain, can use it as a drop-in adder.

The operand is split into consecutive groups. The lowest group is a plain ripple adder fed by the external carry-in. Every higher group ripples its own slice once, taking the incoming carry as zero. An increment stage then adds one to the (width+1)-bit value formed by that group's carry-out and sum. This gives the result for an incoming carry of one without a second adder. The real carry that leaves the group below chooses between the two candidates.

Group widths grow with bit position, so the upper groups have more time before their select carry arrives. The nominal widths are 2, 2, 3, 4, … (group k is k+1 bits wide for k ≥ 1). The last group takes whatever remains so that the widths add up to the operand width. At 128 bits this gives fifteen groups of 2, 2, 3, 4, … 14 and 22 bits, which start at bit offsets 0, 2, 4, 7, 11, 16, 22, 29, 37, 46, 56, 67, 79, 92 and 106.

Top module: `csel_adder128`

## Requirements
- R1: {cout, sum} equals a + b + cin computed at 129 bits, for any operands; zero inputs give a zero sum and carry-out 0.
- R2: The lowest group uses cin directly: with a = b = 0 and cin = 1 the sum is 1 and cout is 0.
- R3: Full-range wrap: all-ones plus one gives sum 0 with cout 1, and all-ones plus all-ones with cin = 1 gives sum all-ones with cout 1.
- R4: In each upper group, the result used when the incoming carry is one equals the carry-zero result (carry-out and sum together) plus one; a group that produces a carry with incoming zero also produces one with incoming one.
- R5: Group boundaries sit at bit offsets 2, 4, 7, 11, 16, 22, 29, 37, 46, 56, 67, 79, 92 and 106. A carry produced below any boundary reaches every higher group: (2^k − 1) + 1 = 2^k, and all-ones + 2^k gives sum 2^k − 1 with cout 1.
- R6: Alternating patterns: 0xAA…A + 0x55…5 gives all-ones with cout 0 when cin = 0, and sum 0 with cout 1 when cin = 1.
- R7: Swapping the two operands does not change the sum or the carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 128 | First addend |
| b | input | 128 | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 128 | Low 128 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 127 |

## Verification
Random operand pairs exercise the ordinary mix of generate and propagate positions. A second random set uses b close to the complement of a, which creates long propagate runs. These stress the carry selects that cross groups, where a wrong select or a wrong increment candidate shows up at once. Operands of the form 2^k − 1 plus one, and all-ones plus 2^k, are placed at every group boundary. They tell apart a carry that stops at a boundary from one that travels through every higher multiplexer. The all-ones, zero-with-carry-in, alternating and operand-swap cases separate errors in the lowest group's use of cin, in the top carry-out, and in asymmetric wiring of the two operands.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Nominal width of group k before the last group takes the remainder.
  function automatic int nominal_w(input int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  // Number of groups that fit into a word of the given width.
  function automatic int group_count(input int width);
    int used;
    int n;
    used = 0;
    n = 0;
    for (int k = 0; k < width; k++) begin
      if (used + nominal_w(k) <= width) begin
        used = used + nominal_w(k);
        n = k + 1;
      end
    end
    if (n == 0) n = 1;
    return n;
  endfunction

  // Lowest bit index of group g.
  function automatic int group_off(input int width, input int g);
    int off;
    off = 0;
    for (int k = 0; k < g; k++) off = off + nominal_w(k);
    return off;
  endfunction

  // Width of group g; the last group absorbs any remainder.
  function automatic int group_w(input int width, input int g);
    if (g == group_count(width) - 1) return width - group_off(width, g);
    return nominal_w(g);
  endfunction

endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  always_comb begin
    logic c;
    c = ci;
    for (int i = 0; i < W; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    co = c;
  end

  // R2: the ripple chain forms the exact group total, carry included
  always_comb begin
    p_ripple_total_r2: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("ripple group total mismatch");
  end

endmodule

// File: rtl/csel_inc.sv
module csel_inc #(
  parameter int W = 4
) (
  input  logic [W:0] val_in,
  output logic [W:0] val_out
);

  // Increment rule: a bit flips when every bit below it is one.
  always_comb begin
    logic all_low;
    all_low = 1'b1;
    for (int i = 0; i <= W; i++) begin
      val_out[i] = val_in[i] ^ all_low;
      all_low    = all_low & val_in[i];
    end
  end

  // R4: converter output is the input plus one
  always_comb begin
    p_plus_one_r4: assert (val_out == val_in + {{W{1'b0}}, 1'b1})
      else $error("increment stage mismatch");
  end

endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] s_zero,
  input  logic         c_zero,
  input  logic [W-1:0] s_one,
  input  logic         c_one,
  output logic [W-1:0] s,
  output logic         co
);

  always_comb begin
    s  = sel ? s_one : s_zero;
    co = sel ? c_one : c_zero;
  end

  // R4: a carry made with incoming zero is also made with incoming one
  always_comb begin
    p_cand_order_r4: assert (!c_zero || c_one)
      else $error("carry candidates out of order");
  end

endmodule

// File: rtl/csel_adder128.sv
module csel_adder128 #(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NGRP = csel_pkg::group_count(WIDTH);

  logic [NGRP:0] grp_c;

  assign grp_c[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int OFF = csel_pkg::group_off(WIDTH, g);
    localparam int GW  = csel_pkg::group_w(WIDTH, g);

    if (g == 0) begin : g_base
      logic [GW-1:0] s_lo;
      logic          c_lo;
      csel_rca #(.W(GW)) u_rca (
        .a (a[OFF +: GW]),
        .b (b[OFF +: GW]),
        .ci(grp_c[0]),
        .s (s_lo),
        .co(c_lo)
      );
      assign sum[OFF +: GW] = s_lo;
      assign grp_c[1]       = c_lo;
    end else begin : g_sel
      logic [GW-1:0] s0;
      logic          c0;
      logic [GW:0]   inc_v;
      logic [GW-1:0] s_fin;
      logic          c_fin;

      csel_rca #(.W(GW)) u_rca (
        .a (a[OFF +: GW]),
        .b (b[OFF +: GW]),
        .ci(1'b0),
        .s (s0),
        .co(c0)
      );

      csel_inc #(.W(GW)) u_inc (
        .val_in ({c0, s0}),
        .val_out(inc_v)
      );

      csel_pick #(.W(GW)) u_pick (
        .sel   (grp_c[g]),
        .s_zero(s0),
        .c_zero(c0),
        .s_one (inc_v[GW-1:0]),
        .c_one (inc_v[GW]),
        .s     (s_fin),
        .co    (c_fin)
      );

      assign sum[OFF +: GW] = s_fin;
      assign grp_c[g+1]     = c_fin;
    end
  end

  assign cout = grp_c[NGRP];

  // R1: the assembled groups give the full-width total
  always_comb begin
    p_full_total_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("adder total mismatch");
  end

endmodule

// File: tb/csel_adder128_test.sv
module csel_adder128_test;

  logic         clk;
  logic [127:0] a;
  logic [127:0] b;
  logic         cin;
  logic [127:0] sum;
  logic         cout;

  int checks;
  int errors;
  bit done;

  csel_adder128 uut (
    .a   (a),
    .b   (b),
    .cin (cin),
    .sum (sum),
    .cout(cout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [128:0] ref_add(input logic [127:0] x, input logic [127:0] y,
                                           input logic ci);
    return {1'b0, x} + {1'b0, y} + {128'd0, ci};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic apply(input logic [127:0] x, input logic [127:0] y, input logic ci);
    @(negedge clk);
    a = x;
    b = y;
    cin = ci;
    @(posedge clk);
    #5;
  endtask

  task automatic expect_val(input string tag, input logic [128:0] exp);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", tag, a, b, cin, {cout, sum}, exp);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] x, input logic [127:0] y,
                     input logic ci);
    apply(x, y, ci);
    expect_val(tag, ref_add(x, y, ci));
  endtask

  initial begin
    a = '0;
    b = '0;
    cin = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] ones;
    logic [127:0] alt_a;
    logic [127:0] alt_b;
    logic [128:0] swap_ref;
    int off;
    checks = 0;
    errors = 0;
    done = 1'b0;
    ones  = '1;
    alt_a = {32{4'hA}};
    alt_b = {32{4'h5}};
    void'($urandom(32'd20240611));

    // R1: zero inputs give zero output
    apply('0, '0, 1'b0);
    expect_val("R1 zero", 129'd0);

    // R2: lowest group takes the external carry-in
    apply('0, '0, 1'b1);
    expect_val("R2 cin only", 129'd1);

    // R3: wrap at full range
    apply(ones, 128'd1, 1'b0);
    expect_val("R3 ones+1", {1'b1, 128'd0});
    apply(ones, ones, 1'b1);
    expect_val("R3 ones+ones+1", {1'b1, ones});
    apply(ones, '0, 1'b1);
    expect_val("R3 ones+cin", {1'b1, 128'd0});

    // R6: alternating patterns
    apply(alt_a, alt_b, 1'b0);
    expect_val("R6 alt cin0", {1'b0, ones});
    apply(alt_a, alt_b, 1'b1);
    expect_val("R6 alt cin1", {1'b1, 128'd0});
    run("R6 alt self", alt_a, alt_a, 1'b1);
    run("R6 alt swap", alt_b, alt_b, 1'b0);

    // R5: carries crossing each group boundary
    off = 0;
    for (int k = 0; k < 14; k++) begin
      off = off + ((k == 0) ? 2 : k + 1);
      apply((128'd1 << off) - 128'd1, 128'd1, 1'b0);
      expect_val($sformatf("R5 boundary %0d rise", off), {1'b0, 128'd1 << off});
      apply(ones, 128'd1 << off, 1'b0);
      expect_val($sformatf("R5 boundary %0d wrap", off), {1'b1, (128'd1 << off) - 128'd1});
      run($sformatf("R4 boundary %0d inc", off), (128'd1 << off) - 128'd1, '0, 1'b1);
    end

    // R1: random operands
    for (int n = 0; n < 1500; n++) begin
      logic [127:0] x;
      logic [127:0] y;
      x = rnd128();
      y = rnd128();
      run("R1 random", x, y, 1'($urandom));
    end

    // R4: long propagate runs stress the carry-one candidates
    for (int n = 0; n < 400; n++) begin
      logic [127:0] x;
      logic [127:0] y;
      x = rnd128();
      y = ~x ^ (128'd1 << ($urandom % 128));
      run("R4 propagate", x, y, 1'($urandom));
    end

    // R7: operand order does not matter
    for (int n = 0; n < 50; n++) begin
      logic [127:0] x;
      logic [127:0] y;
      logic         ci;
      x  = rnd128();
      y  = rnd128();
      ci = 1'($urandom);
      apply(x, y, ci);
      swap_ref = {cout, sum};
      apply(y, x, ci);
      expect_val("R7 swap", swap_ref);
      expect_val("R7 swap ref", ref_add(x, y, ci));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule